// File: doc/BRIEF.md
# Memory Boundary-Scan Test Port

This block is the serial test port of a synchronous memory device. A 16-state controller advances on the rising edge of the test clock under the mode-select input. A 3-bit instruction register selects the data path that sits between serial input and serial output. Three data paths are available: a single-bit pass-through register, a 32-bit identification register loaded from a constant, and a boundary register of parameterised length that captures the state of the memory's I/O ring.

The instruction decode departs from the usual boundary-scan conventions in several ways:
- The all-zeros code is not an external test. It acts as a pass-through.
- The reserved codes and the private code also act as pass-through.
- The sample code only captures. Nothing shifted in is ever applied.
- One code samples the ring and, at the same time, drives an output-disable signal that puts every memory data driver in high impedance.

The serial output changes on the falling edge of the test clock. It is qualified by an enable that is high only while shifting. A synchronous active-high reset, or five consecutive rising edges with mode-select high, returns the controller to its reset state. That state reloads the identification instruction.

Top module: `mem_scan_tap`

## Requirements
- R1: While and after `rst`, the controller sits in reset, the active instruction is 001 (identify), `tdo_en` is 0 and `mem_out_hiz` is 0.
- R2: Five consecutive rising `tck` edges with `tms` high reach the reset state from any state, and this restores instruction 001 and clears `mem_out_hiz`.
- R3: When the instruction register is captured, it loads 3'b001. It shifts out LSB first, so the bits seen on `tdo` are 1, 0, 0. Instruction bits enter from `tdi` LSB first.
- R4: Under instruction 001, data capture loads `ID_VALUE` into the 32-bit identification register, which then shifts out LSB first.
- R5: Codes 000, 011, 101, 110 and 111 select a 1-bit pass-through register that captures 0. Each `tdi` bit appears on `tdo` one shift later.
- R6: Under code 010, the boundary register captures `ring_in` and shifts it out LSB first. `tdi` enters at its MSB, so shifted data emerges after `BSR_LEN` shifts.
- R7: Under code 010 and only then, `mem_out_hiz` is 1. It changes on the falling `tck` edge of the instruction update state.
- R8: Code 100 captures `ring_in` into the boundary register with `mem_out_hiz` 0. Shifted-in data is never applied, and the next capture again shows `ring_in`.
- R9: `tdo_en` is 1 only in the two shift states. It and `tdo` update on the falling `tck` edge.
- R10: The active instruction changes only on the falling edge in the instruction update state or in the reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| ring_in | input | BSR_LEN | Parallel state of the memory I/O ring |
| tdo | output | 1 | Serial data out, changes on falling tck |
| tdo_en | output | 1 | High while tdo carries valid data |
| mem_out_hiz | output | 1 | Forces the memory data drivers to high impedance |

## Verification
The controller state and every capture or shift take effect on the rising edge at which the state is left. A new instruction, `mem_out_hiz`, `tdo` and `tdo_en` follow on the next falling edge. The bench therefore drives `tms` and `tdi` and samples all outputs one nanosecond after each falling edge. At that point the first captured bit is already on `tdo` in the first shift state, and the output-disable level already reflects an instruction updated half a clock earlier. Expected scan contents come from a bench function that builds each code's captured word and then appends the delayed `tdi` stream.

// File: rtl/mem_tap_pkg.sv
package mem_tap_pkg;

    localparam int IR_W = 3;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [IR_W-1:0] {
        OP_ZERO     = 3'b000,
        OP_IDENT    = 3'b001,
        OP_SCAN_HIZ = 3'b010,
        OP_RES_A    = 3'b011,
        OP_SCAN     = 3'b100,
        OP_VENDOR   = 3'b101,
        OP_RES_B    = 3'b110,
        OP_PASS     = 3'b111
    } tap_op_e;

    typedef enum logic [1:0] {PATH_PASS, PATH_IDENT, PATH_RING} dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     hiz;
    } op_decode_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        case (s)
            ST_RESET:  return tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   return tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: return tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: return tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: return tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: return tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: return tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: return tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: return tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: return tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return tms ? ST_UPD_IR : ST_SHF_IR;
            default:   return tms ? ST_SEL_DR : ST_IDLE;
        endcase
    endfunction

    function automatic op_decode_t decode_op(input tap_op_e op);
        op_decode_t d;
        d.hiz = 1'b0;
        case (op)
            OP_IDENT:    d.path = PATH_IDENT;
            OP_SCAN_HIZ: begin d.path = PATH_RING; d.hiz = 1'b1; end
            OP_SCAN:     d.path = PATH_RING;
            default:     d.path = PATH_PASS;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mem_tap_fsm.sv
module mem_tap_fsm
    import mem_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);
    always_ff @(posedge tck) begin
        if (rst) state <= ST_RESET;
        else     state <= tap_next(state, tms);
    end
endmodule

// File: rtl/mem_tap_ir.sv
module mem_tap_ir
    import mem_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  tap_state_e state,
    input  logic       tdi,
    output logic       ir_lsb,
    output tap_op_e    active_op
);
    logic [IR_W-1:0] ir_sr;

    always_ff @(posedge tck) begin
        if (rst)                    ir_sr <= IR_CAPTURE;
        else if (state == ST_CAP_IR) ir_sr <= IR_CAPTURE;
        else if (state == ST_SHF_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    always_ff @(negedge tck) begin
        if (state == ST_RESET)       active_op <= OP_IDENT;
        else if (state == ST_UPD_IR) active_op <= tap_op_e'(ir_sr);
    end

    assign ir_lsb = ir_sr[0];
endmodule

// File: rtl/mem_tap_dr.sv
module mem_tap_dr
    import mem_tap_pkg::*;
#(
    parameter int          BSR_LEN  = 16,
    parameter logic [31:0] ID_VALUE = 32'h0B3C_5A71
) (
    input  logic               tck,
    input  logic               rst,
    input  tap_state_e         state,
    input  dr_path_e           path,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] ring_in,
    output logic               dr_lsb
);
    localparam int ID_W = 32;

    logic               pass_q;
    logic [ID_W-1:0]    id_q;
    logic [BSR_LEN-1:0] ring_q;
    logic [BSR_LEN-1:0] ring_shifted;

    generate
        if (BSR_LEN == 1) begin : g_ring_one
            assign ring_shifted = tdi;
        end else begin : g_ring_many
            assign ring_shifted = {tdi, ring_q[BSR_LEN-1:1]};
        end
    endgenerate

    always_ff @(posedge tck) begin
        if (rst) begin
            pass_q <= 1'b0;
            id_q   <= ID_VALUE;
            ring_q <= '0;
        end else if (state == ST_CAP_DR) begin
            case (path)
                PATH_IDENT: id_q   <= ID_VALUE;
                PATH_RING:  ring_q <= ring_in;
                default:    pass_q <= 1'b0;
            endcase
        end else if (state == ST_SHF_DR) begin
            case (path)
                PATH_IDENT: id_q   <= {tdi, id_q[ID_W-1:1]};
                PATH_RING:  ring_q <= ring_shifted;
                default:    pass_q <= tdi;
            endcase
        end
    end

    always_comb begin
        case (path)
            PATH_IDENT: dr_lsb = id_q[0];
            PATH_RING:  dr_lsb = ring_q[0];
            default:    dr_lsb = pass_q;
        endcase
    end
endmodule

// File: rtl/mem_scan_tap.sv
module mem_scan_tap
    import mem_tap_pkg::*;
#(
    parameter int          BSR_LEN  = 16,
    parameter logic [31:0] ID_VALUE = 32'h0B3C_5A71
) (
    input  logic               tck,
    input  logic               rst,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] ring_in,
    output logic               tdo,
    output logic               tdo_en,
    output logic               mem_out_hiz
);
    tap_state_e state;
    tap_op_e    active_op;
    op_decode_t dec;
    logic       ir_lsb;
    logic       dr_lsb;

    mem_tap_fsm u_fsm (.tck(tck), .rst(rst), .tms(tms), .state(state));

    mem_tap_ir u_ir (
        .tck(tck), .rst(rst), .state(state), .tdi(tdi),
        .ir_lsb(ir_lsb), .active_op(active_op)
    );

    assign dec = decode_op(active_op);

    mem_tap_dr #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VALUE)) u_dr (
        .tck(tck), .rst(rst), .state(state), .path(dec.path),
        .tdi(tdi), .ring_in(ring_in), .dr_lsb(dr_lsb)
    );

    always_ff @(negedge tck) begin
        tdo_en <= (state == ST_SHF_IR) || (state == ST_SHF_DR);
        tdo    <= (state == ST_SHF_IR) ? ir_lsb : dr_lsb;
    end

    assign mem_out_hiz = dec.hiz;
endmodule

// File: rtl/mem_tap_chk.sv
module mem_tap_chk
    import mem_tap_pkg::*;
(
    input logic       tck,
    input logic       rst,
    input logic       tms,
    input logic       tdo_en,
    input logic       mem_out_hiz,
    input tap_state_e state,
    input tap_op_e    active_op
);
    logic [2:0] hi_cnt;

    always_ff @(posedge tck) begin
        if (rst || !tms)       hi_cnt <= '0;
        else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
    end

    // R2
    five_high_reset_chk: assert property (@(posedge tck) disable iff (rst)
        (hi_cnt == 3'd5) |-> (state == ST_RESET));

    // R9
    tdo_en_shift_chk: assert property (@(posedge tck) disable iff (rst)
        tdo_en |-> (state == ST_SHF_DR || state == ST_SHF_IR));

    // R7
    hiz_rise_chk: assert property (@(posedge tck) disable iff (rst)
        $rose(mem_out_hiz) |-> (state == ST_UPD_IR));

    // R10
    op_hold_chk: assert property (@(posedge tck) disable iff (rst)
        !$stable(active_op) |-> (state == ST_UPD_IR || state == ST_RESET));

    // R1
    reset_op_chk: assert property (@(posedge tck) disable iff (rst)
        (state == ST_RESET && $past(state) == ST_RESET) |-> (active_op == OP_IDENT && !mem_out_hiz));
endmodule

bind mem_scan_tap mem_tap_chk u_chk (
    .tck(tck), .rst(rst), .tms(tms), .tdo_en(tdo_en), .mem_out_hiz(mem_out_hiz),
    .state(state), .active_op(active_op)
);

// File: tb/mem_scan_tap_bench.sv
`timescale 1ns/100ps
module mem_scan_tap_bench;
    localparam int          BSR_LEN  = 16;
    localparam logic [31:0] ID_VALUE = 32'h0B3C_5A71;

    logic tck = 1'b0;
    logic rst = 1'b1;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic [BSR_LEN-1:0] ring_in = '0;
    logic tdo, tdo_en, mem_out_hiz;
    int checks = 0;
    int failures = 0;

    always #2 tck = ~tck;

    mem_scan_tap #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VALUE)) u_mem_scan_tap (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .ring_in(ring_in),
        .tdo(tdo), .tdo_en(tdo_en), .mem_out_hiz(mem_out_hiz)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d);
        tms = m; tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic go_idle();
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
        tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            cap[i] = tdo;
            tick(i == 2, code[i]);
        end
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din,
                           output logic [63:0] dout, output logic en_seen);
        dout = '0;
        tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
        en_seen = tdo_en;
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            tick(i == n - 1, din[i]);
        end
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    function automatic int path_len(input logic [2:0] code);
        if (code == 3'b001) return 32;
        if (code == 3'b010 || code == 3'b100) return BSR_LEN;
        return 1;
    endfunction

    function automatic logic [63:0] exp_scan(input logic [2:0] code, input int n,
                                             input logic [63:0] din, input logic [BSR_LEN-1:0] ring);
        logic [63:0] capv;
        logic [63:0] r;
        int len;
        len = path_len(code);
        if (code == 3'b001) capv = {32'd0, ID_VALUE};
        else if (len == BSR_LEN && code != 3'b001) capv = {{(64-BSR_LEN){1'b0}}, ring};
        else capv = '0;
        r = '0;
        for (int i = 0; i < n; i++) r[i] = (i < len) ? capv[i] : din[i - len];
        return r;
    endfunction

    function automatic string req_of(input logic [2:0] code);
        if (code == 3'b001) return "R4";
        if (code == 3'b010) return "R6";
        if (code == 3'b100) return "R8";
        return "R5";
    endfunction

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, -1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [2:0]  cap;
        logic [63:0] dout;
        logic [63:0] din;
        logic        en;
        int          n;
        void'($urandom(32'd2024));

        tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b1, 1'b0);
        // R1: reset outputs
        check("R1 tdo_en", {63'd0, tdo_en}, 64'd0);
        check("R1 hiz", {63'd0, mem_out_hiz}, 64'd0);
        rst = 1'b0;
        tick(1'b0, 1'b0);
        // R1 / R4: identify selected after reset
        scan_dr(32, 64'd0, dout, en);
        check("R1 R4 id scan", dout, {32'd0, ID_VALUE});
        check("R9 tdo_en in shift", {63'd0, en}, 64'd1);
        check("R9 tdo_en idle", {63'd0, tdo_en}, 64'd0);

        // R3: capture pattern
        load_ir(3'b111, cap);
        check("R3 ir capture", {61'd0, cap}, 64'd1);

        // R5: pass-through delay with all-zeros code
        load_ir(3'b000, cap);
        check("R5 hiz", {63'd0, mem_out_hiz}, 64'd0);
        din = 64'h0000_0000_0000_00B5;
        scan_dr(9, din, dout, en);
        check("R5 zero code", dout, exp_scan(3'b000, 9, din, ring_in));

        // R7 / R6: output-disable with ring capture, then shifted data emerges
        ring_in = 16'hC3A5;
        load_ir(3'b010, cap);
        check("R7 hiz on", {63'd0, mem_out_hiz}, 64'd1);
        din = 64'h0000_0000_0000_5E;
        scan_dr(BSR_LEN + 8, din, dout, en);
        check("R6 ring scan", dout, exp_scan(3'b010, BSR_LEN + 8, din, ring_in));
        check("R7 hiz holds", {63'd0, mem_out_hiz}, 64'd1);

        // R8: capture only, no preload
        load_ir(3'b100, cap);
        check("R8 hiz off", {63'd0, mem_out_hiz}, 64'd0);
        din = 64'h0000_0000_0000_FFFF;
        scan_dr(BSR_LEN, din, dout, en);
        check("R8 first", dout, exp_scan(3'b100, BSR_LEN, din, ring_in));
        ring_in = 16'h1234;
        scan_dr(BSR_LEN, 64'd0, dout, en);
        check("R8 no preload", dout, {48'd0, ring_in});

        // R2: five tms high from a shift state restores identify
        load_ir(3'b010, cap);
        tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
        check("R2 hiz cleared", {63'd0, mem_out_hiz}, 64'd0);
        tick(1'b0, 1'b0);
        scan_dr(32, 64'd0, dout, en);
        check("R2 id restored", dout, {32'd0, ID_VALUE});

        // R10: instruction held across data scans and pauses
        load_ir(3'b010, cap);
        tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0);
        tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0);
        check("R10 op held", {63'd0, mem_out_hiz}, 64'd1);

        // random codes
        for (int k = 0; k < 40; k++) begin
            logic [2:0] code;
            code = 3'($urandom % 8);
            ring_in = 16'($urandom);
            din = {$urandom, $urandom};
            n = path_len(code) + int'($urandom % 8);
            load_ir(code, cap);
            check("R3 capture", {61'd0, cap}, 64'd1);
            check("R7 hiz", {63'd0, mem_out_hiz}, {63'd0, code == 3'b010});
            scan_dr(n, din, dout, en);
            check(req_of(code), dout, exp_scan(code, n, din, ring_in));
            if (k % 10 == 9) begin
                for (int j = 0; j < 6; j++) tick(1'($urandom), 1'b0);
                go_idle();
                check("R2 hiz after reset", {63'd0, mem_out_hiz}, 64'd0);
            end
        end

        // R1: synchronous reset mid-scan
        load_ir(3'b010, cap);
        rst = 1'b1;
        tick(1'b0, 1'b0);
        check("R1 hiz reset", {63'd0, mem_out_hiz}, 64'd0);
        rst = 1'b0;
        tick(1'b0, 1'b0);
        scan_dr(32, 64'd0, dout, en);
        check("R1 id after reset", dout, {32'd0, ID_VALUE});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule